// File: doc/BRIEF.md
# Stream Operation Dispatcher

This block sits between a host processor and the stream clients of a stream-oriented media engine. The host runs the scalar program. It forwards only the stream-level work to this block through the head of a command FIFO. There are four kinds of work: moving a stream from external memory into the stream buffer, moving a stream from the buffer out to memory, loading a kernel's code into the kernel instruction store, and running a kernel over buffered streams. The block sends each operation to one of two memory transfer channels or to the single kernel execution unit. Several operations can therefore be in progress at the same time.

The block issues operations strictly in program order, at most one per cycle, and clients may finish them in any order. For each stream-buffer region it counts the outstanding readers and writers, and it holds the head command back while that command would break a data dependency. It also records which kernel is resident, so that a repeated kernel load is retired at once without touching the kernel unit. A global cap bounds the number of outstanding operations. Back-pressure is applied by holding `cmd_ready` low.

Top module: `stream_op_dispatch`

## Requirements
- R1: After reset the block reports zero outstanding operations, `stat_idle` high and no resident kernel (`stat_res_vld` low), and it asserts no start to any client.
- R2: Opcode 0 (stream into buffer, writes region `cmd_ra`) and opcode 1 (stream out of buffer, reads region `cmd_ra`) go to memory channel 0 when that channel is ready and holds fewer than `CH_DEPTH` unfinished transfers, otherwise to channel 1 under the same condition. `mem_start` bit i selects channel i, and `mem_to_buf` is 1 for opcode 0. With neither channel able to accept, the command is not taken.
- R3: A command that reads a region (opcode 1, or the input `cmd_ra` of opcode 3) is not taken while any outstanding operation writes that region.
- R4: A command that writes a region (opcode 0, or the outputs of opcode 3) is not taken while any outstanding operation reads or writes that region.
- R5: Independent operations issue on consecutive cycles, so a kernel run and transfers on both memory channels can be outstanding together.
- R6: No more than `MAX_OUT` operations are ever outstanding. At that limit `cmd_ready` is low even when a client could accept.
- R7: Opcode 2 (kernel load) naming the kernel id already recorded as resident, or currently being loaded, is taken in one cycle with no client start and without occupying an outstanding slot.
- R8: Any other opcode 2 starts the kernel unit with `kern_load` high and records `cmd_kid` as resident. The kernel unit holds one operation at a time, so opcodes 2 and 3 wait while it is busy.
- R9: While the head command cannot issue, no client start is asserted.
- R10: Completions may arrive in any order (per memory channel, in issue order). A done pulse frees its regions and its outstanding slot in the cycle after it is sampled.
- R11: Opcode 3 writes `cmd_rc` only when `cmd_rc_en` is 1. With `cmd_rc_en` at 0 that region is neither tracked nor waited on, and `kern_out1_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Head of host command FIFO is valid |
| cmd_ready | output | 1 | Head command is taken this cycle if valid |
| cmd_op | input | 2 | 0 stream in, 1 stream out, 2 kernel load, 3 kernel run |
| cmd_ra | input | RW | Transfer region, or kernel input region |
| cmd_rb | input | RW | Kernel first output region |
| cmd_rc | input | RW | Kernel second output region |
| cmd_rc_en | input | 1 | Second output region in use |
| cmd_kid | input | KID_W | Kernel identifier |
| cmd_arg | input | ARG_W | Memory address or stream length, passed through |
| mem_ready | input | 2 | Channel can accept a start |
| mem_start | output | 2 | Start pulse per channel |
| mem_to_buf | output | 1 | 1 = memory to buffer, 0 = buffer to memory |
| mem_region | output | RW | Buffer region of the transfer |
| mem_arg | output | ARG_W | Transfer argument |
| mem_done | input | 2 | Per-channel completion pulse, in issue order |
| kern_start | output | 1 | Start pulse to kernel unit |
| kern_load | output | 1 | 1 = load code, 0 = run |
| kern_id | output | KID_W | Kernel identifier |
| kern_in | output | RW | Input region |
| kern_out0 | output | RW | First output region |
| kern_out1 | output | RW | Second output region |
| kern_out1_en | output | 1 | Second output in use |
| kern_arg | output | ARG_W | Kernel argument (length) |
| kern_done | input | 1 | Kernel unit completion pulse |
| stat_outstanding | output | OW | Number of outstanding operations |
| stat_res_id | output | KID_W | Resident kernel id |
| stat_res_vld | output | 1 | Resident kernel id is valid |
| stat_idle | output | 1 | Nothing outstanding |

## Verification
A corrupted region counter shows at the ports in one of two ways. Either a dependent command is taken and started while it should wait, or `cmd_ready` stays low after the last conflicting done, and both show in the cycle after that done. A corrupted channel queue pops the wrong entry. This shows as a dependency released too early or too late, and as a wrong `stat_outstanding` count once the queue drains. Residency faults show as a start on a repeated kernel load, or as a missing start on a new one, in the same cycle the command is presented.

// File: rtl/stream_op_dispatch.sv
module stream_op_dispatch #(
  parameter int NREG     = 8,
  parameter int KID_W    = 3,
  parameter int ARG_W    = 16,
  parameter int CH_DEPTH = 4,
  parameter int MAX_OUT  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [1:0]                    cmd_op,
  input  logic [$clog2(NREG)-1:0]       cmd_ra,
  input  logic [$clog2(NREG)-1:0]       cmd_rb,
  input  logic [$clog2(NREG)-1:0]       cmd_rc,
  input  logic                          cmd_rc_en,
  input  logic [KID_W-1:0]              cmd_kid,
  input  logic [ARG_W-1:0]              cmd_arg,
  input  logic [1:0]                    mem_ready,
  output logic [1:0]                    mem_start,
  output logic                          mem_to_buf,
  output logic [$clog2(NREG)-1:0]       mem_region,
  output logic [ARG_W-1:0]              mem_arg,
  input  logic [1:0]                    mem_done,
  output logic                          kern_start,
  output logic                          kern_load,
  output logic [KID_W-1:0]              kern_id,
  output logic [$clog2(NREG)-1:0]       kern_in,
  output logic [$clog2(NREG)-1:0]       kern_out0,
  output logic [$clog2(NREG)-1:0]       kern_out1,
  output logic                          kern_out1_en,
  output logic [ARG_W-1:0]              kern_arg,
  input  logic                          kern_done,
  output logic [$clog2(MAX_OUT+1)-1:0]  stat_outstanding,
  output logic [KID_W-1:0]              stat_res_id,
  output logic                          stat_res_vld,
  output logic                          stat_idle
);
  localparam int RW = $clog2(NREG);
  localparam int CW = $clog2(2*MAX_OUT+1);
  localparam int OW = $clog2(MAX_OUT+1);
  localparam int PW = $clog2(CH_DEPTH);
  localparam logic [OW-1:0] OUT_LIM = OW'(MAX_OUT);
  localparam logic [PW:0]   Q_FULL  = (PW+1)'(CH_DEPTH);
  localparam logic [1:0] OP_IN = 2'd0, OP_OUT = 2'd1, OP_LDK = 2'd2, OP_RUN = 2'd3;

  logic [CW-1:0] wr_cnt [NREG];
  logic [CW-1:0] rd_cnt [NREG];
  logic [CW-1:0] w_inc [NREG], w_dec [NREG], r_inc [NREG], r_dec [NREG];
  logic [OW-1:0] out_cnt;

  logic          q_wr [2][CH_DEPTH];
  logic [RW-1:0] q_rg [2][CH_DEPTH];
  logic [PW-1:0] q_hd [2], q_tl [2];
  logic [PW:0]   q_n  [2];

  logic          k_busy, k_run, k_o1en;
  logic [RW-1:0] k_in, k_o0, k_o1;
  logic [KID_W-1:0] res_id;
  logic          res_vld;

  logic is_mem, rd_a, wr_a, wr_b, wr_c, hit, deps_ok, can, fire, iss, dk;
  logic [1:0] ch_ok, d_ch;

  assign is_mem = (cmd_op == OP_IN) || (cmd_op == OP_OUT);
  assign wr_a   = cmd_op == OP_IN;
  assign rd_a   = (cmd_op == OP_OUT) || (cmd_op == OP_RUN);
  assign wr_b   = cmd_op == OP_RUN;
  assign wr_c   = (cmd_op == OP_RUN) && cmd_rc_en;
  assign hit    = (cmd_op == OP_LDK) && res_vld && (cmd_kid == res_id);

  assign deps_ok = (!rd_a || wr_cnt[cmd_ra] == '0)
                && (!wr_a || (wr_cnt[cmd_ra] == '0 && rd_cnt[cmd_ra] == '0))
                && (!wr_b || (wr_cnt[cmd_rb] == '0 && rd_cnt[cmd_rb] == '0))
                && (!wr_c || (wr_cnt[cmd_rc] == '0 && rd_cnt[cmd_rc] == '0));

  assign ch_ok[0] = mem_ready[0] && (q_n[0] != Q_FULL);
  assign ch_ok[1] = mem_ready[1] && (q_n[1] != Q_FULL);

  assign can = hit || ((out_cnt < OUT_LIM) && deps_ok && (is_mem ? |ch_ok : !k_busy));
  assign cmd_ready = can;
  assign fire = cmd_valid && can;
  assign iss  = fire && !hit;

  assign mem_start[0] = iss && is_mem && ch_ok[0];
  assign mem_start[1] = iss && is_mem && !ch_ok[0];
  assign mem_to_buf   = wr_a;
  assign mem_region   = cmd_ra;
  assign mem_arg      = cmd_arg;

  assign kern_start   = iss && !is_mem;
  assign kern_load    = cmd_op == OP_LDK;
  assign kern_id      = cmd_kid;
  assign kern_in      = cmd_ra;
  assign kern_out0    = cmd_rb;
  assign kern_out1    = cmd_rc;
  assign kern_out1_en = wr_c;
  assign kern_arg     = cmd_arg;

  assign d_ch[0] = mem_done[0] && (q_n[0] != '0);
  assign d_ch[1] = mem_done[1] && (q_n[1] != '0);
  assign dk      = kern_done && k_busy;

  assign stat_outstanding = out_cnt;
  assign stat_res_id      = res_id;
  assign stat_res_vld     = res_vld;
  assign stat_idle        = out_cnt == '0;

  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      w_inc[r] = CW'(iss && wr_a && cmd_ra == RW'(r))
               + CW'(iss && wr_b && cmd_rb == RW'(r))
               + CW'(iss && wr_c && cmd_rc == RW'(r));
      r_inc[r] = CW'(iss && rd_a && cmd_ra == RW'(r));
      w_dec[r] = CW'(d_ch[0] && q_wr[0][q_hd[0]] && q_rg[0][q_hd[0]] == RW'(r))
               + CW'(d_ch[1] && q_wr[1][q_hd[1]] && q_rg[1][q_hd[1]] == RW'(r))
               + CW'(dk && k_run && k_o0 == RW'(r))
               + CW'(dk && k_run && k_o1en && k_o1 == RW'(r));
      r_dec[r] = CW'(d_ch[0] && !q_wr[0][q_hd[0]] && q_rg[0][q_hd[0]] == RW'(r))
               + CW'(d_ch[1] && !q_wr[1][q_hd[1]] && q_rg[1][q_hd[1]] == RW'(r))
               + CW'(dk && k_run && k_in == RW'(r));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        wr_cnt[r] <= '0;
        rd_cnt[r] <= '0;
      end
      out_cnt <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        wr_cnt[r] <= wr_cnt[r] + w_inc[r] - w_dec[r];
        rd_cnt[r] <= rd_cnt[r] + r_inc[r] - r_dec[r];
      end
      out_cnt <= out_cnt + OW'(iss) - OW'(d_ch[0]) - OW'(d_ch[1]) - OW'(dk);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        q_hd[c] <= '0;
        q_tl[c] <= '0;
        q_n[c]  <= '0;
        for (int e = 0; e < CH_DEPTH; e++) begin
          q_wr[c][e] <= 1'b0;
          q_rg[c][e] <= '0;
        end
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (mem_start[c]) begin
          q_wr[c][q_tl[c]] <= wr_a;
          q_rg[c][q_tl[c]] <= cmd_ra;
          q_tl[c] <= q_tl[c] + PW'(1);
        end
        if (d_ch[c]) q_hd[c] <= q_hd[c] + PW'(1);
        q_n[c] <= q_n[c] + (PW+1)'(mem_start[c]) - (PW+1)'(d_ch[c]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_busy  <= 1'b0;
      k_run   <= 1'b0;
      k_o1en  <= 1'b0;
      k_in    <= '0;
      k_o0    <= '0;
      k_o1    <= '0;
      res_id  <= '0;
      res_vld <= 1'b0;
    end else begin
      if (kern_start) begin
        k_busy <= 1'b1;
        k_run  <= cmd_op == OP_RUN;
        k_in   <= cmd_ra;
        k_o0   <= cmd_rb;
        k_o1   <= cmd_rc;
        k_o1en <= wr_c;
        if (cmd_op == OP_LDK) begin
          res_id  <= cmd_kid;
          res_vld <= 1'b1;
        end
      end else if (dk) begin
        k_busy <= 1'b0;
      end
    end
  end

  assert_outstanding_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cnt <= OUT_LIM);

  assert_single_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_start, kern_start}) <= 1 && (!cmd_valid || !cmd_ready || hit || (mem_start != 2'b00) || kern_start));

  assert_reload_skipped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LDK && res_vld && cmd_kid == res_id) |-> (cmd_ready && !kern_start && mem_start == 2'b00));

  assert_kernel_serial_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kern_start |-> !k_busy);

  assert_kernel_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kern_start |=> k_busy);

  for (genvar g = 0; g < NREG; g++) begin : g_reg_chk
    assert_read_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_start != 2'b00) && !mem_to_buf && mem_region == RW'(g)) |-> (wr_cnt[g] == '0));
    assert_write_after_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_start != 2'b00) && mem_to_buf && mem_region == RW'(g)) |-> (wr_cnt[g] == '0 && rd_cnt[g] == '0));
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cnt[g] == '0 && rd_cnt[g] == '0) |=> (wr_cnt[g] <= CW'(2*MAX_OUT) && rd_cnt[g] <= CW'(MAX_OUT)));
  end
endmodule

// File: tb/stream_op_dispatch_test.sv
module stream_op_dispatch_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_ready, cmd_rc_en;
  logic [1:0] cmd_op;
  logic [2:0] cmd_ra, cmd_rb, cmd_rc, cmd_kid;
  logic [15:0] cmd_arg;
  logic [1:0] mem_ready, mem_start, mem_done;
  logic       mem_to_buf;
  logic [2:0] mem_region;
  logic [15:0] mem_arg, kern_arg;
  logic       kern_start, kern_load, kern_out1_en, kern_done;
  logic [2:0] kern_id, kern_in, kern_out0, kern_out1;
  logic [3:0] stat_outstanding;
  logic [2:0] stat_res_id;
  logic       stat_res_vld, stat_idle;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  stream_op_dispatch uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_rc(cmd_rc),
    .cmd_rc_en(cmd_rc_en), .cmd_kid(cmd_kid), .cmd_arg(cmd_arg),
    .mem_ready(mem_ready), .mem_start(mem_start), .mem_to_buf(mem_to_buf),
    .mem_region(mem_region), .mem_arg(mem_arg), .mem_done(mem_done),
    .kern_start(kern_start), .kern_load(kern_load), .kern_id(kern_id),
    .kern_in(kern_in), .kern_out0(kern_out0), .kern_out1(kern_out1),
    .kern_out1_en(kern_out1_en), .kern_arg(kern_arg), .kern_done(kern_done),
    .stat_outstanding(stat_outstanding), .stat_res_id(stat_res_id),
    .stat_res_vld(stat_res_vld), .stat_idle(stat_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [1:0] op, input int a, input int b, input int c, input bit en, input int k);
    cmd_op = op; cmd_ra = 3'(a); cmd_rb = 3'(b); cmd_rc = 3'(c);
    cmd_rc_en = en; cmd_kid = 3'(k); cmd_arg = 16'(a * 16 + k);
    cmd_valid = 1'b1;
    #1;
  endtask

  task automatic pulse(input logic [1:0] md, input bit kd);
    mem_done = md; kern_done = kd;
    tick;
    mem_done = 2'b00; kern_done = 1'b0;
    #1;
  endtask

  task automatic pair(input logic [1:0] op1, input int a, input logic [1:0] op2, input int b,
                      input bit blk, input string req);
    put(op1, a, 0, 0, 0, 0);
    chk(cmd_ready && mem_start == 2'b01 && mem_to_buf == (op1 == 2'd0) && mem_region == 3'(a),
        "R2", int'(mem_start), 1);
    tick; cmd_valid = 1'b0;
    put(op2, b, 0, 0, 0, 0);
    chk(cmd_ready == !blk, req, int'(cmd_ready), int'(!blk));
    if (blk) begin
      tick; #1;
      chk(!cmd_ready && mem_start == 2'b00 && !kern_start, "R9", int'(mem_start), 0);
      pulse(2'b01, 1'b0);
      chk(cmd_ready && mem_start == 2'b01, "R10", int'(cmd_ready), 1);
      tick; cmd_valid = 1'b0;
      pulse(2'b01, 1'b0);
    end else begin
      chk(mem_start == 2'b01, "R5", int'(mem_start), 1);
      tick; cmd_valid = 1'b0;
      pulse(2'b01, 1'b0);
      pulse(2'b01, 1'b0);
    end
    chk(stat_outstanding == 0 && stat_idle, "R10", int'(stat_outstanding), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int prev;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_ra = '0; cmd_rb = '0; cmd_rc = '0;
    cmd_rc_en = 1'b0; cmd_kid = '0; cmd_arg = '0; mem_ready = 2'b11; mem_done = 2'b00; kern_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stat_outstanding == 0, "R1", int'(stat_outstanding), 0);
    chk(stat_idle && !stat_res_vld, "R1", int'(stat_res_vld), 0);
    chk(mem_start == 2'b00 && !kern_start, "R1", int'(mem_start), 0);

    // R3 read after write, R4 write after read and write after write, full region sweep
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) begin
        pair(2'd0, a, 2'd1, b, a == b, "R3");
        pair(2'd1, a, 2'd0, b, a == b, "R4");
        pair(2'd0, a, 2'd0, b, a == b, "R4");
        pair(2'd1, a, 2'd1, b, 1'b0, "R3");
      end

    // R6 cap and R2 channel overflow routing
    for (int i = 0; i < 7; i++) begin
      put(2'd0, i, 0, 0, 0, 0);
      chk(mem_start == (i < 4 ? 2'b01 : 2'b10), "R2", int'(mem_start), (i < 4 ? 1 : 2));
      tick;
    end
    put(2'd2, 0, 0, 0, 0, 1);
    chk(kern_start && kern_load && kern_id == 3'd1, "R8", int'(kern_start), 1);
    tick; cmd_valid = 1'b0; #1;
    chk(stat_outstanding == 8, "R6", int'(stat_outstanding), 8);
    put(2'd1, 7, 0, 0, 0, 0);
    chk(!cmd_ready && mem_start == 2'b00, "R6", int'(cmd_ready), 0);
    tick; #1;
    chk(!cmd_ready, "R6", int'(cmd_ready), 0);
    pulse(2'b00, 1'b1);
    chk(cmd_ready && mem_start == 2'b10, "R6", int'(mem_start), 2);
    chk(stat_res_vld && stat_res_id == 3'd1, "R8", int'(stat_res_id), 1);
    tick; cmd_valid = 1'b0;
    for (int i = 0; i < 4; i++) pulse(2'b11, 1'b0);
    chk(stat_outstanding == 0 && stat_idle, "R10", int'(stat_outstanding), 0);

    // R7 and R8 residency sweep
    prev = 1;
    for (int i = 0; i < 16; i++) begin
      int k = i / 2;
      put(2'd2, 0, 0, 0, 0, k);
      if (k == prev) begin
        chk(cmd_ready && !kern_start, "R7", int'(kern_start), 0);
        tick; cmd_valid = 1'b0; #1;
        chk(stat_outstanding == 0, "R7", int'(stat_outstanding), 0);
      end else begin
        chk(cmd_ready && kern_start && kern_load && kern_id == 3'(k), "R8", int'(kern_id), k);
        tick; cmd_valid = 1'b0; #1;
        chk(stat_res_vld && stat_res_id == 3'(k), "R8", int'(stat_res_id), k);
        put(2'd2, 0, 0, 0, 0, k);
        chk(cmd_ready && !kern_start, "R7", int'(kern_start), 0);
        tick; cmd_valid = 1'b0; #1;
        chk(stat_outstanding == 1, "R7", int'(stat_outstanding), 1);
        put(2'd2, 0, 0, 0, 0, (k + 1) % 8);
        chk(!cmd_ready && !kern_start, "R8", int'(cmd_ready), 0);
        cmd_valid = 1'b0;
        pulse(2'b00, 1'b1);
        chk(stat_outstanding == 0, "R10", int'(stat_outstanding), 0);
        prev = k;
      end
    end

    // Kernel run with two outputs; dependencies and concurrency
    put(2'd3, 2, 3, 4, 1, 7);
    chk(kern_start && !kern_load && kern_in == 3'd2 && kern_out0 == 3'd3 && kern_out1 == 3'd4 && kern_out1_en,
        "R11", int'(kern_out1), 4);
    tick; cmd_valid = 1'b0;
    put(2'd1, 3, 0, 0, 0, 0); chk(!cmd_ready, "R3", int'(cmd_ready), 0);
    put(2'd1, 4, 0, 0, 0, 0); chk(!cmd_ready, "R11", int'(cmd_ready), 0);
    put(2'd0, 2, 0, 0, 0, 0); chk(!cmd_ready, "R4", int'(cmd_ready), 0);
    put(2'd0, 3, 0, 0, 0, 0); chk(!cmd_ready, "R4", int'(cmd_ready), 0);
    put(2'd3, 5, 6, 0, 0, 7); chk(!cmd_ready && !kern_start, "R8", int'(cmd_ready), 0);
    put(2'd1, 2, 0, 0, 0, 0); chk(cmd_ready && mem_start == 2'b01, "R5", int'(mem_start), 1);
    tick;
    put(2'd0, 5, 0, 0, 0, 0); chk(cmd_ready && mem_start == 2'b01, "R5", int'(mem_start), 1);
    tick; cmd_valid = 1'b0; #1;
    chk(stat_outstanding == 3, "R5", int'(stat_outstanding), 3);
    pulse(2'b00, 1'b1);
    put(2'd1, 3, 0, 0, 0, 0); chk(cmd_ready, "R10", int'(cmd_ready), 1);
    tick; cmd_valid = 1'b0;
    for (int i = 0; i < 3; i++) pulse(2'b01, 1'b0);
    chk(stat_idle, "R10", int'(stat_outstanding), 0);

    // R11 second output disabled
    put(2'd3, 2, 3, 4, 0, 7);
    chk(kern_start && !kern_out1_en, "R11", int'(kern_out1_en), 0);
    tick;
    put(2'd1, 4, 0, 0, 0, 0); chk(cmd_ready, "R11", int'(cmd_ready), 1);
    tick; cmd_valid = 1'b0;
    pulse(2'b01, 1'b1);
    chk(stat_idle, "R10", int'(stat_outstanding), 0);

    // R2 channel readiness
    mem_ready = 2'b00;
    put(2'd0, 0, 0, 0, 0, 0); chk(!cmd_ready && mem_start == 2'b00, "R2", int'(cmd_ready), 0);
    mem_ready = 2'b10; #1;
    chk(cmd_ready && mem_start == 2'b10, "R2", int'(mem_start), 2);
    tick; cmd_valid = 1'b0; mem_ready = 2'b11;
    pulse(2'b10, 1'b0);
    chk(stat_idle, "R10", int'(stat_outstanding), 0);

    // R9 blocked head holds everything
    put(2'd3, 0, 1, 0, 0, 7);
    tick; cmd_valid = 1'b0;
    put(2'd0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      chk(!cmd_ready && mem_start == 2'b00 && !kern_start, "R9", int'(mem_start), 0);
      tick; #1;
    end
    pulse(2'b00, 1'b1);
    chk(cmd_ready && mem_start == 2'b01, "R10", int'(mem_start), 1);
    tick; cmd_valid = 1'b0;
    pulse(2'b01, 1'b0);
    chk(stat_idle && stat_outstanding == 0, "R10", int'(stat_outstanding), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule